// File: doc/BRIEF.md
# Column-Scan Frame Sequencer

This block sets the output schedule for a display made of one line of pixel drivers whose image is swept column by column across the screen. Each frame has two parts. In the first, columns are written to the downstream converter stage. In the second, the scanner returns to its start position and every pixel drive is held at the zero code. The sequencer follows the incoming frame sync. It marks the start of each output frame with a one-cycle sync pulse and issues a strobe at the start of each column slot.

The number of columns written per frame is programmable and clamped to a legal range. Writing fewer columns gives each column a longer slot, which leaves more settling time for the analog drivers. All durations are parameters counted in clock cycles.

If the input sync goes missing, the sequencer free-runs at the nominal period and flags the loss of lock. It locks to the input again once the sync reappears with regular spacing.

Top module: `colscan_frame_seq`

## Requirements
- R1: While rst_ni is low, phase_o reads 0 (idle), and frame_sync_o, col_start_o, lock_lost_o and pix_o are all zero.
- R2: In the idle phase with lock held, a sync sampled high on a clock edge starts a frame at that edge. phase_o becomes 1 (active) and frame_sync_o is high for exactly the first active cycle.
- R3: The active phase lasts ACTIVE_CYC cycles. It is followed by FLYBACK_CYC cycles with phase_o = 2 (flyback). With lock held, phase_o then returns to 0 (idle).
- R4: pix_o equals pix_i during the active phase and is all zeros during flyback and idle.
- R5: col_count_i is an unsigned column count. Values below MIN_COLS are treated as MIN_COLS and values above MAX_COLS as MAX_COLS. The value is taken from the input one clock before the frame starts and then held for that whole frame.
- R6: With an effective count N and a slot length S = floor(ACTIVE_CYC / N), col_start_o pulses at active cycle offsets k*S for k = 0..N-1, and col_idx_o equals k during that pulse. There are no strobes in the remainder cycles at the end of the active window, and none outside the active phase.
- R7: A sync arriving during the active or flyback phase neither restarts nor alters the frame in progress.
- R8: With lock held, if no frame has started for 1.5 × (ACTIVE_CYC + FLYBACK_CYC) cycles, a frame starts anyway. lock_lost_o rises on that same edge.
- R9: While lock_lost_o is high, frames follow one another back to back every ACTIVE_CYC + FLYBACK_CYC cycles, and input syncs do not start frames.
- R10: A sync is in tolerance when its edge-to-edge spacing from the previous sync lies within nominal period ± TOL_CYC, bounds included. lock_lost_o clears on the second consecutive in-tolerance sync. An out-of-tolerance sync resets this count.
- R11: Once lock_lost_o has cleared, the current frame ends in idle and the next input sync starts a frame as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_sync_i | input | 1 | Incoming frame sync, one-cycle pulse |
| col_count_i | input | COL_W | Requested columns per frame |
| pix_i | input | PIX_W | Pixel code from the column data path |
| phase_o | output | 2 | Phase: 0 idle, 1 active, 2 flyback |
| frame_sync_o | output | 1 | Frame sync to the converter stage |
| col_start_o | output | 1 | Column slot start strobe |
| col_idx_o | output | COL_W | Index of the column being started |
| pix_o | output | PIX_W | Pixel code, forced to zero outside active |
| lock_lost_o | output | 1 | Sequencer is free-running without input lock |

## Verification
A wrong frame counter shows up on phase_o within one cycle of the intended boundary: at active cycle ACTIVE_CYC, at the end of flyback, or at the timeout cycle. A wrong slot length or column latch moves or drops a col_start_o pulse in the first slot where the error applies. A faulty tolerance window or a faulty consecutive-sync count appears only on lock_lost_o, and only at the edge of the sync that should have cleared it, so these syncs are placed exactly on both tolerance bounds and just outside one of them.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ACTIVE  = 2'd1,
    PH_FLYBACK = 2'd2
  } phase_e;
endpackage

// File: rtl/fseq_cfg.sv
// Clamp requested column count and derive slot length, one register stage.
module fseq_cfg #(
  parameter int unsigned ACTIVE_CYC = 1708333,
  parameter int unsigned MIN_COLS   = 480,
  parameter int unsigned MAX_COLS   = 640,
  parameter int unsigned COL_W      = 10,
  parameter int unsigned SLOT_W     = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [COL_W-1:0]  col_count_i,
  output logic [COL_W-1:0]  cols_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [31:0] ACT32 = 32'(ACTIVE_CYC);

  logic [COL_W-1:0]  clamp_d;
  logic [SLOT_W-1:0] slot_d;

  always_comb begin
    if (col_count_i < COL_W'(MIN_COLS))      clamp_d = COL_W'(MIN_COLS);
    else if (col_count_i > COL_W'(MAX_COLS)) clamp_d = COL_W'(MAX_COLS);
    else                                     clamp_d = col_count_i;
    slot_d = SLOT_W'(ACT32 / 32'(clamp_d));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cols_o <= COL_W'(MIN_COLS);
      slot_o <= SLOT_W'(ACTIVE_CYC / MIN_COLS);
    end else begin
      cols_o <= clamp_d;
      slot_o <= slot_d;
    end
  end
endmodule

// File: rtl/fseq_sync_mon.sv
// Measures sync spacing; flags the second consecutive in-tolerance sync.
module fseq_sync_mon #(
  parameter int unsigned NOM_CYC = 2083333,
  parameter int unsigned TOL_CYC = 2083,
  parameter int unsigned G_W     = 22
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic relock_o
);
  localparam logic [G_W-1:0] GMAX = '1;
  localparam logic [31:0]    LO   = 32'(NOM_CYC - TOL_CYC);
  localparam logic [31:0]    HI   = 32'(NOM_CYC + TOL_CYC);

  logic [G_W-1:0] gap_q;
  logic           good_q;
  logic [31:0]    gap32;
  logic           in_tol;

  always_comb begin
    gap32    = 32'(gap_q) + 32'd1;
    in_tol   = (gap32 >= LO) && (gap32 <= HI);
    relock_o = sync_i && in_tol && good_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= GMAX;
      good_q <= 1'b0;
    end else if (sync_i) begin
      gap_q  <= '0;
      good_q <= in_tol;
    end else if (gap_q != GMAX) begin
      gap_q  <= gap_q + 1'b1;
    end
  end
endmodule

// File: rtl/fseq_col_pacer.sv
// Column slot counter; latches count and slot length at frame start.
module fseq_col_pacer #(
  parameter int unsigned COL_W  = 10,
  parameter int unsigned SLOT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              run_i,
  input  logic [COL_W-1:0]  cols_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              strobe_o,
  output logic [COL_W-1:0]  idx_o
);
  logic [COL_W-1:0]  cols_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] sub_q;

  assign strobe_o = run_i && (sub_q == '0) && (idx_o < cols_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cols_q <= '0;
      slot_q <= SLOT_W'(1);
      sub_q  <= '0;
      idx_o  <= '0;
    end else if (start_i) begin
      cols_q <= cols_i;
      slot_q <= slot_i;
      sub_q  <= '0;
      idx_o  <= '0;
    end else if (run_i) begin
      if (sub_q == slot_q - 1'b1) begin
        sub_q <= '0;
        if (idx_o != cols_q) idx_o <= idx_o + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/colscan_frame_seq.sv
module colscan_frame_seq
  import fseq_pkg::*;
#(
  parameter int unsigned ACTIVE_CYC  = 1708333,
  parameter int unsigned FLYBACK_CYC = 375000,
  parameter int unsigned MIN_COLS    = 480,
  parameter int unsigned MAX_COLS    = 640,
  parameter int unsigned TOL_CYC     = 2083,
  parameter int unsigned PIX_W       = 14,
  localparam int unsigned COL_W      = $clog2(MAX_COLS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_sync_i,
  input  logic [COL_W-1:0] col_count_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic [1:0]       phase_o,
  output logic             frame_sync_o,
  output logic             col_start_o,
  output logic [COL_W-1:0] col_idx_o,
  output logic [PIX_W-1:0] pix_o,
  output logic             lock_lost_o
);
  localparam int unsigned NOM_CYC = ACTIVE_CYC + FLYBACK_CYC;
  localparam int unsigned TMO_CYC = NOM_CYC + NOM_CYC / 2;
  localparam int unsigned F_W     = $clog2(TMO_CYC + 1);
  localparam int unsigned SLOT_W  = $clog2(ACTIVE_CYC / MIN_COLS + 1);
  localparam int unsigned G_W     = $clog2(NOM_CYC + TOL_CYC + 2);

  phase_e            state_q, state_d;
  logic [F_W-1:0]    f_cnt_q, f_cnt_d;
  logic              lock_q, lock_d;
  logic              timeout, end_frame, start_frame, relock;
  logic [COL_W-1:0]  cols_r;
  logic [SLOT_W-1:0] slot_r;

  fseq_cfg #(
    .ACTIVE_CYC(ACTIVE_CYC), .MIN_COLS(MIN_COLS), .MAX_COLS(MAX_COLS),
    .COL_W(COL_W), .SLOT_W(SLOT_W)
  ) i_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .col_count_i(col_count_i),
    .cols_o(cols_r), .slot_o(slot_r)
  );

  fseq_sync_mon #(
    .NOM_CYC(NOM_CYC), .TOL_CYC(TOL_CYC), .G_W(G_W)
  ) i_sync_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(frame_sync_i), .relock_o(relock)
  );

  fseq_col_pacer #(
    .COL_W(COL_W), .SLOT_W(SLOT_W)
  ) i_pacer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(start_frame), .run_i(state_q == PH_ACTIVE),
    .cols_i(cols_r), .slot_i(slot_r),
    .strobe_o(col_start_o), .idx_o(col_idx_o)
  );

  always_comb begin
    timeout     = !lock_q && (f_cnt_q == F_W'(TMO_CYC - 1));
    end_frame   = (state_q == PH_FLYBACK) && (f_cnt_q == F_W'(NOM_CYC - 1));
    // locked: start on input sync or timeout; lost: free-run back to back
    start_frame = lock_q ? end_frame
                         : (state_q == PH_IDLE) && (frame_sync_i || timeout);

    state_d = state_q;
    f_cnt_d = f_cnt_q + 1'b1;
    if (start_frame) begin
      state_d = PH_ACTIVE;
      f_cnt_d = '0;
    end else begin
      unique case (state_q)
        PH_ACTIVE:  if (f_cnt_q == F_W'(ACTIVE_CYC - 1)) state_d = PH_FLYBACK;
        PH_FLYBACK: if (end_frame)                       state_d = PH_IDLE;
        default:    state_d = PH_IDLE;
      endcase
    end

    lock_d = lock_q;
    if (!lock_q && start_frame && !frame_sync_i) lock_d = 1'b1;
    else if (lock_q && relock)                   lock_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      f_cnt_q <= '0;
      lock_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      f_cnt_q <= f_cnt_d;
      lock_q  <= lock_d;
    end
  end

  assign phase_o      = state_q;
  assign frame_sync_o = (state_q == PH_ACTIVE) && (f_cnt_q == '0);
  assign pix_o        = (state_q == PH_ACTIVE) ? pix_i : '0;
  assign lock_lost_o  = lock_q;
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
  parameter int unsigned MAX_COLS = 640,
  parameter int unsigned COL_W    = 10,
  parameter int unsigned PIX_W    = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       phase_o,
  input logic             frame_sync_o,
  input logic             col_start_o,
  input logic [COL_W-1:0] col_idx_o,
  input logic [PIX_W-1:0] pix_o,
  input logic             lock_lost_o
);
  // R2
  fs_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_o |=> !frame_sync_o);
  // R2
  fs_in_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_o |-> phase_o == 2'd1);
  // R2
  active_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd1 && $past(phase_o) != 2'd1) |-> frame_sync_o);
  // R4
  blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != 2'd1 |-> pix_o == '0);
  // R6
  col_in_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_start_o |-> phase_o == 2'd1);
  // R5
  col_idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_start_o |-> col_idx_o < COL_W'(MAX_COLS));
  // R8
  lock_loss_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_lost_o) |-> frame_sync_o);
  // R3
  phase_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != 2'd3);
endmodule

bind colscan_frame_seq fseq_chk #(
  .MAX_COLS(MAX_COLS), .COL_W(COL_W), .PIX_W(PIX_W)
) i_fseq_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .phase_o(phase_o),
  .frame_sync_o(frame_sync_o), .col_start_o(col_start_o),
  .col_idx_o(col_idx_o), .pix_o(pix_o), .lock_lost_o(lock_lost_o)
);

// File: tb/test_colscan_frame_seq.sv
module test_colscan_frame_seq;
  localparam int ACT = 60;
  localparam int FLY = 20;
  localparam int NOM = ACT + FLY;
  localparam int TMO = NOM + NOM / 2;
  localparam int MINC = 4;
  localparam int MAXC = 8;
  localparam int TOL = 4;

  logic       clk, rst_n, vsync;
  logic [3:0] col_count;
  logic [7:0] pix_in;
  logic [1:0] phase;
  logic       fs, cs, lock;
  logic [3:0] idx;
  logic [7:0] pix_out;

  int n_chk = 0;
  int n_fail = 0;

  colscan_frame_seq #(
    .ACTIVE_CYC(ACT), .FLYBACK_CYC(FLY), .MIN_COLS(MINC), .MAX_COLS(MAXC),
    .TOL_CYC(TOL), .PIX_W(8)
  ) i_colscan_frame_seq (
    .clk_i(clk), .rst_ni(rst_n), .frame_sync_i(vsync), .col_count_i(col_count),
    .pix_i(pix_in), .phase_o(phase), .frame_sync_o(fs), .col_start_o(cs),
    .col_idx_o(idx), .pix_o(pix_out), .lock_lost_o(lock)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse();
    vsync = 1'b1;
    tick();
    vsync = 1'b0;
  endtask

  // current sample point is active cycle 0 of a frame
  task automatic check_frame(input int raw, input bit lost, input bit inject);
    int ce = (raw < MINC) ? MINC : (raw > MAXC) ? MAXC : raw;
    int sl = ACT / ce;
    string rc = (raw < MINC || raw > MAXC) ? "R5" : "R6";
    string rf = inject ? "R7" : "R2";
    for (int c = 0; c < NOM; c++) begin
      bit est;
      pix_in = 8'h80 | 8'(c);
      #1;
      est = (c < ACT) && (c % sl == 0) && (c / sl < ce);
      chk(inject ? "R7 phase" : "R3 phase", int'(phase), (c < ACT) ? 1 : 2);
      chk({rf, " frame_sync"}, int'(fs), (c == 0) ? 1 : 0);
      chk({rc, " col_start"}, int'(cs), int'(est));
      if (est) chk({rc, " col_idx"}, int'(idx), c / sl);
      chk("R4 pix", int'(pix_out), (c < ACT) ? int'(pix_in) : 0);
      chk(lost ? "R9 lock_lost" : "R2 lock_lost", int'(lock), int'(lost));
      if (inject && (c == 30 || c == 70)) vsync = 1'b1;
      tick();
      vsync = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int vals[9] = '{6, 4, 8, 5, 7, 3, 0, 9, 15};
    rst_n = 1'b0;
    vsync = 1'b0;
    col_count = 4'd6;
    pix_in = 8'hff;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 phase", int'(phase), 0);
    chk("R1 frame_sync", int'(fs), 0);
    chk("R1 col_start", int'(cs), 0);
    chk("R1 pix", int'(pix_out), 0);
    chk("R1 lock_lost", int'(lock), 0);
    rst_n = 1'b1;
    tick();

    // column count sweep, locked frames
    foreach (vals[i]) begin
      col_count = 4'(vals[i]);
      tick();
      pulse();
      check_frame(vals[i], 1'b0, i == 2);
      chk("R3 idle", int'(phase), 0);
      chk("R4 idle pix", int'(pix_out), 0);
    end

    // no sync: wait for timeout (sample now at frame cycle NOM)
    for (int c = NOM; c < TMO; c++) begin
      chk("R8 wait phase", int'(phase), 0);
      chk("R8 wait lock", int'(lock), 0);
      tick();
    end
    chk("R8 timeout start", int'(fs), 1);
    chk("R8 lock set", int'(lock), 1);
    check_frame(15, 1'b1, 1'b0);
    check_frame(15, 1'b1, 1'b0);

    // relock: spacings 80 in, 85 out, 84 in, 76 in
    pulse();
    repeat (NOM - 1) tick();
    pulse();
    chk("R10 one good", int'(lock), 1);
    repeat (NOM + TOL) tick();
    pulse();
    chk("R10 out of tol", int'(lock), 1);
    repeat (NOM + TOL - 1) tick();
    pulse();
    chk("R10 count reset", int'(lock), 1);
    repeat (NOM - TOL - 1) tick();
    pulse();
    chk("R10 relock", int'(lock), 0);

    for (int k = 0; k < 100 && phase != 2'd0; k++) tick();
    chk("R11 idle after relock", int'(phase), 0);
    pulse();
    check_frame(15, 1'b0, 1'b0);
    chk("R11 idle", int'(phase), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule